// File: doc/BRIEF.md
# Deep Standby Power Sequencer

This block runs the lowest-power mode of a small processor subsystem. Software uses a simple register port to program entry permission, a retention mask for RAM pages, the wake pins and their edge polarity, and a settle delay. When the CPU then raises its sleep strobe with both permission bits set, the block steps the subsystem down in a fixed order. It freezes the I/O pads at their current levels, stops the clocks, and removes power from the core and the peripherals. Only the RAM pages named in the keep mask stay powered.

While powered down, the block watches the enabled wake pins through a synchronizer. It accepts only a single rising or a single falling edge. An accepted edge starts the power-up sequence, which is the entry sequence in reverse with a programmable settle wait before the clocks restart. The pin that caused the wake is recorded in a sticky flag register, which software clears by writing ones. The core and peripheral domains are held in reset from power-off until the clocks run again, so they restart from their reset values.

Top module: `dstby_ctrl`

## Requirements
- R1: A register write lands on the clock edge where `reg_we` is high, and `reg_rdata` shows the new value from the next cycle. The addresses are:
  - 0: control. Bit 0 is standby permit, bit 1 is deep permit, and bits 5:2 are the RAM keep mask.
  - 1: wake enable, one bit per pin.
  - 2: wake mode, two bits per pin; pin p uses bits 2p+1:2p.
  - 3: wake flags.
  - 4: settle count, bits 5:0.
  - Unmapped addresses read 0.
- R2: A `sleep_req` pulse starts the power-down sequence only when both the standby and the deep permit bits are 1. With either bit 0, the outputs do not change.
- R3: Entry takes one state per step. In the cycle after the accepted request, `io_hold` is 1 and the clock is still on. One cycle later `clk_en` is 0. One cycle after that, `core_pwr_en` and `periph_pwr_en` are 0, `domain_rst` is 1 and `in_standby` is 1.
- R4: While `in_standby` is 1, `ram_pwr_en` equals the keep mask. At all other times every page is powered.
- R5: Once `io_hold` is 1, `pad_out` keeps the value `core_pad_out` had at the accepting edge, until `io_hold` falls. When not holding, `pad_out` follows `core_pad_out`.
- R6: A wake pin whose enable bit is 0 never ends standby and never sets its flag.
- R7: Wake mode codes are 00 for falling edge, 01 for rising edge, 10 for low level and 11 for both edges. Only 00 and 01 end standby. Codes 10 and 11 never wake the block.
- R8: With two synchronizer stages and settle count S, the first cycle with `clk_en` at 1 comes S+4 cycles after the edge at which the wake pin changes. `domain_rst` falls one cycle later, and `io_hold` falls one cycle after that.
- R9: An accepted wake sets that pin's flag. The flag stays set until software writes 1 to it at address 3, after which it reads back 0.
- R10: Returning to normal mode clears the standby and deep permit bits and keeps the RAM keep mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| sleep_req | input | 1 | Sleep request strobe from the CPU |
| wake_pin | input | 4 | Asynchronous wake inputs |
| core_pad_out | input | 8 | Pad levels driven by the functional logic |
| pad_out | output | 8 | Pad levels after the freeze multiplexer |
| io_hold | output | 1 | Pad hold enable |
| clk_en | output | 1 | Clock enable for core and peripherals |
| core_pwr_en | output | 1 | Core power switch enable |
| periph_pwr_en | output | 1 | Peripheral power switch enable |
| domain_rst | output | 1 | Reset for the power-gated domains |
| ram_pwr_en | output | 4 | Per-page retention RAM power enable |
| in_standby | output | 1 | High while powered down |

## Verification
The assertions rely on three conditions. The control bits and keep mask do not change while the block is powered down. `core_pad_out` is driven from the bench only. `sleep_req` is a plain strobe that the sequencer ignores outside normal mode. The bench writes registers only in normal mode and sends wake edges only after the power-down sequence has settled. It returns the block to a known state with a reset before each sweep trial, so every trial starts with the wake pins low and no stale edges in the synchronizer.

// File: rtl/dstby_pkg.sv
package dstby_pkg;

   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_HOLD   = 3'd1,
      ST_CLKOFF = 3'd2,
      ST_OFF    = 3'd3,
      ST_PWRON  = 3'd4,
      ST_SETTLE = 3'd5,
      ST_CLKON  = 3'd6,
      ST_UNHOLD = 3'd7
   } dstby_state_e;

   // register map
   localparam int A_CTRL   = 0;
   localparam int A_WEN    = 1;
   localparam int A_WMODE  = 2;
   localparam int A_WFLAG  = 3;
   localparam int A_SETTLE = 4;

   // control register fields
   localparam int CTRL_STBY_BIT = 0;
   localparam int CTRL_DEEP_BIT = 1;
   localparam int CTRL_KEEP_LSB = 2;

   // wake mode codes
   localparam logic [1:0] WM_FALL  = 2'b00;
   localparam logic [1:0] WM_RISE  = 2'b01;
   localparam logic [1:0] WM_LOW   = 2'b10;
   localparam logic [1:0] WM_BOTH  = 2'b11;

endpackage

// File: rtl/dstby_regs.sv
module dstby_regs
   import dstby_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int N_WAKE   = 4,
   parameter int N_PAGES  = 4,
   parameter int SETTLE_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   input  logic [N_WAKE-1:0]     flag_set,
   input  logic                  exit_clr,
   output logic                  stby,
   output logic                  deep,
   output logic [N_PAGES-1:0]    keep,
   output logic [N_WAKE-1:0]     wake_en,
   output logic [2*N_WAKE-1:0]   wake_mode,
   output logic [SETTLE_W-1:0]   settle,
   output logic [N_WAKE-1:0]     flags
);

   localparam int MODE_W = 2 * N_WAKE;

   logic sel_ctrl, sel_wen, sel_wmode, sel_wflag, sel_settle;
   logic [N_WAKE-1:0] clr_mask;

   assign sel_ctrl   = (addr == ADDR_W'(A_CTRL));
   assign sel_wen    = (addr == ADDR_W'(A_WEN));
   assign sel_wmode  = (addr == ADDR_W'(A_WMODE));
   assign sel_wflag  = (addr == ADDR_W'(A_WFLAG));
   assign sel_settle = (addr == ADDR_W'(A_SETTLE));

   assign clr_mask = (we && sel_wflag) ? wdata[N_WAKE-1:0] : '0;

   // permit bits: cleared on the way back to normal mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby <= 1'b0;
         deep <= 1'b0;
      end else if (exit_clr) begin
         stby <= 1'b0;
         deep <= 1'b0;
      end else if (we && sel_ctrl) begin
         stby <= wdata[CTRL_STBY_BIT];
         deep <= wdata[CTRL_DEEP_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep      <= '0;
         wake_en   <= '0;
         wake_mode <= '0;
         settle    <= '0;
      end else if (we) begin
         if (sel_ctrl)   keep      <= wdata[CTRL_KEEP_LSB +: N_PAGES];
         if (sel_wen)    wake_en   <= wdata[N_WAKE-1:0];
         if (sel_wmode)  wake_mode <= wdata[MODE_W-1:0];
         if (sel_settle) settle    <= wdata[SETTLE_W-1:0];
      end
   end

   // sticky flags, write-one-to-clear, a new set wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_mask) | flag_set;
   end

   always_comb begin
      rdata = '0;
      if (sel_ctrl) begin
         rdata[CTRL_STBY_BIT] = stby;
         rdata[CTRL_DEEP_BIT] = deep;
         rdata[CTRL_KEEP_LSB +: N_PAGES] = keep;
      end else if (sel_wen) begin
         rdata[N_WAKE-1:0] = wake_en;
      end else if (sel_wmode) begin
         rdata[MODE_W-1:0] = wake_mode;
      end else if (sel_wflag) begin
         rdata[N_WAKE-1:0] = flags;
      end else if (sel_settle) begin
         rdata[SETTLE_W-1:0] = settle;
      end
   end

endmodule

// File: rtl/dstby_wake.sv
module dstby_wake
   import dstby_pkg::*;
#(
   parameter int N_WAKE      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_WAKE-1:0]    pin,
   input  logic [N_WAKE-1:0]    en,
   input  logic [2*N_WAKE-1:0]  mode,
   input  logic                 arm,
   output logic [N_WAKE-1:0]    hit
);

   logic [N_WAKE-1:0] sync_q [SYNC_STAGES];
   logic [N_WAKE-1:0] prev_q;
   logic [N_WAKE-1:0] cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
         prev_q <= '0;
      end else begin
         sync_q[0] <= pin;
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur = sync_q[SYNC_STAGES-1];

   // per-pin qualification: only a single chosen edge counts
   for (genvar p = 0; p < N_WAKE; p++) begin : g_pin
      logic rise, fall, edge_ok;
      logic [1:0] m;
      assign m    = mode[2*p +: 2];
      assign rise = cur[p] & ~prev_q[p];
      assign fall = ~cur[p] & prev_q[p];
      always_comb begin
         unique case (m)
            WM_RISE: edge_ok = rise;
            WM_FALL: edge_ok = fall;
            default: edge_ok = 1'b0;   // level and both-edge refused
         endcase
      end
      assign hit[p] = arm & en[p] & edge_ok;
   end

endmodule

// File: rtl/dstby_seq.sv
module dstby_seq
   import dstby_pkg::*;
#(
   parameter int SETTLE_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_req,
   input  logic                 permit,
   input  logic                 wake_any,
   input  logic [SETTLE_W-1:0]  settle,
   output logic                 accept,
   output logic                 exit_done,
   output logic                 arm,
   output logic                 io_hold,
   output logic                 clk_en,
   output logic                 pwr_en,
   output logic                 dom_rst,
   output logic                 in_standby
);

   dstby_state_e        state_q, state_d;
   logic [SETTLE_W-1:0] cnt_q;

   assign accept = (state_q == ST_RUN) && sleep_req && permit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (accept) state_d = ST_HOLD;
         ST_HOLD:   state_d = ST_CLKOFF;
         ST_CLKOFF: state_d = ST_OFF;
         ST_OFF:    if (wake_any) state_d = ST_PWRON;
         ST_PWRON:  state_d = ST_SETTLE;
         ST_SETTLE: if (cnt_q == settle) state_d = ST_CLKON;
         ST_CLKON:  state_d = ST_UNHOLD;
         ST_UNHOLD: state_d = ST_RUN;
         default:   state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_SETTLE) cnt_q <= '0;
         else if (cnt_q != settle) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign io_hold    = (state_q != ST_RUN);
   assign clk_en     = (state_q == ST_RUN) || (state_q == ST_HOLD) ||
                       (state_q == ST_CLKON) || (state_q == ST_UNHOLD);
   assign pwr_en     = (state_q != ST_OFF);
   assign dom_rst    = (state_q == ST_OFF) || (state_q == ST_PWRON) ||
                       (state_q == ST_SETTLE) || (state_q == ST_CLKON);
   assign in_standby = (state_q == ST_OFF);
   assign arm        = (state_q == ST_OFF);
   assign exit_done  = (state_q == ST_UNHOLD);

endmodule

// File: rtl/dstby_pinhold.sv
module dstby_pinhold #(
   parameter int N_IO    = 8,
   parameter int N_PAGES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic                hold,
   input  logic [N_IO-1:0]     core_pad,
   output logic [N_IO-1:0]     pad_out,
   input  logic                standby,
   input  logic [N_PAGES-1:0]  keep,
   output logic [N_PAGES-1:0]  ram_pwr
);

   logic [N_IO-1:0] frozen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frozen_q <= '0;
      else if (capture) frozen_q <= core_pad;
   end

   for (genvar i = 0; i < N_IO; i++) begin : g_pad
      assign pad_out[i] = hold ? frozen_q[i] : core_pad[i];
   end

   for (genvar g = 0; g < N_PAGES; g++) begin : g_page
      assign ram_pwr[g] = standby ? keep[g] : 1'b1;
   end

endmodule

// File: rtl/dstby_ctrl.sv
module dstby_ctrl
   import dstby_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int N_WAKE      = 4,
   parameter int N_IO        = 8,
   parameter int N_PAGES     = 4,
   parameter int SETTLE_W    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic                 sleep_req,
   input  logic [N_WAKE-1:0]    wake_pin,
   input  logic [N_IO-1:0]      core_pad_out,
   output logic [N_IO-1:0]      pad_out,
   output logic                 io_hold,
   output logic                 clk_en,
   output logic                 core_pwr_en,
   output logic                 periph_pwr_en,
   output logic                 domain_rst,
   output logic [N_PAGES-1:0]   ram_pwr_en,
   output logic                 in_standby
);

   localparam int MODE_W = 2 * N_WAKE;

   if (MODE_W > DATA_W) begin : g_chk_mode
      $error("wake mode field wider than data bus");
   end
   if (CTRL_KEEP_LSB + N_PAGES > DATA_W) begin : g_chk_keep
      $error("keep mask does not fit control register");
   end
   if (SETTLE_W > DATA_W) begin : g_chk_settle
      $error("settle count wider than data bus");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("wake synchronizer needs at least two stages");
   end
   if ((1 << ADDR_W) <= A_SETTLE) begin : g_chk_addr
      $error("address bus too narrow for register map");
   end

   logic                  ctrl_stby, ctrl_deep;
   logic [N_PAGES-1:0]    keep_mask;
   logic [N_WAKE-1:0]     wake_en;
   logic [MODE_W-1:0]     wake_mode;
   logic [SETTLE_W-1:0]   settle_cnt;
   logic [N_WAKE-1:0]     wake_flags;
   logic [N_WAKE-1:0]     wake_hit;
   logic                  accept, exit_done, arm, pwr_en;

   dstby_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WAKE(N_WAKE),
      .N_PAGES(N_PAGES), .SETTLE_W(SETTLE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .flag_set(wake_hit), .exit_clr(exit_done),
      .stby(ctrl_stby), .deep(ctrl_deep), .keep(keep_mask),
      .wake_en(wake_en), .wake_mode(wake_mode), .settle(settle_cnt),
      .flags(wake_flags)
   );

   dstby_wake #(
      .N_WAKE(N_WAKE), .SYNC_STAGES(SYNC_STAGES)
   ) u_wake (
      .clk(clk), .rst_n(rst_n),
      .pin(wake_pin), .en(wake_en), .mode(wake_mode),
      .arm(arm), .hit(wake_hit)
   );

   dstby_seq #(
      .SETTLE_W(SETTLE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .sleep_req(sleep_req), .permit(ctrl_stby & ctrl_deep),
      .wake_any(|wake_hit), .settle(settle_cnt),
      .accept(accept), .exit_done(exit_done), .arm(arm),
      .io_hold(io_hold), .clk_en(clk_en), .pwr_en(pwr_en),
      .dom_rst(domain_rst), .in_standby(in_standby)
   );

   dstby_pinhold #(
      .N_IO(N_IO), .N_PAGES(N_PAGES)
   ) u_pins (
      .clk(clk), .rst_n(rst_n),
      .capture(accept), .hold(io_hold),
      .core_pad(core_pad_out), .pad_out(pad_out),
      .standby(in_standby), .keep(keep_mask), .ram_pwr(ram_pwr_en)
   );

   assign core_pwr_en   = pwr_en;
   assign periph_pwr_en = pwr_en;

endmodule

// File: rtl/dstby_ctrl_sva.sv
module dstby_ctrl_sva #(
   parameter int N_WAKE  = 4,
   parameter int N_IO    = 8,
   parameter int N_PAGES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sleep_req,
   input logic                ctrl_stby,
   input logic                ctrl_deep,
   input logic [N_PAGES-1:0]  keep_mask,
   input logic [N_WAKE-1:0]   wake_flags,
   input logic [N_WAKE-1:0]   wake_hit,
   input logic [N_IO-1:0]     pad_out,
   input logic                io_hold,
   input logic                clk_en,
   input logic                core_pwr_en,
   input logic                periph_pwr_en,
   input logic                domain_rst,
   input logic [N_PAGES-1:0]  ram_pwr_en,
   input logic                in_standby
);

   p_entry_permit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_hold) |-> $past(sleep_req && ctrl_stby && ctrl_deep));

   p_hold_before_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> io_hold);

   p_clock_on_at_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_hold) |-> clk_en);

   p_power_off_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_en |-> (!clk_en && domain_rst && !periph_pwr_en));

   p_ram_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_standby |-> (ram_pwr_en == keep_mask));

   p_ram_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_standby |-> (&ram_pwr_en));

   p_pad_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_hold && $past(io_hold)) |-> $stable(pad_out));

   p_wake_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_standby) |-> $past(|wake_hit));

   p_flag_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(wake_flags & ~$past(wake_flags))) |-> $past(in_standby));

   p_one_wake_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake_hit) |-> in_standby);

endmodule

bind dstby_ctrl dstby_ctrl_sva #(
   .N_WAKE(N_WAKE), .N_IO(N_IO), .N_PAGES(N_PAGES)
) u_sva (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
   .ctrl_stby(ctrl_stby), .ctrl_deep(ctrl_deep), .keep_mask(keep_mask),
   .wake_flags(wake_flags), .wake_hit(wake_hit), .pad_out(pad_out),
   .io_hold(io_hold), .clk_en(clk_en), .core_pwr_en(core_pwr_en),
   .periph_pwr_en(periph_pwr_en), .domain_rst(domain_rst),
   .ram_pwr_en(ram_pwr_en), .in_standby(in_standby)
);

// File: tb/dstby_ctrl_tb.sv
module dstby_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sleep_req = 1'b0;
   logic [3:0] wake_pin = '0;
   logic [7:0] core_pad_out = '0;
   logic [7:0] pad_out;
   logic       io_hold, clk_en, core_pwr_en, periph_pwr_en, domain_rst, in_standby;
   logic [3:0] ram_pwr_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dstby_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
      .wake_pin(wake_pin), .core_pad_out(core_pad_out), .pad_out(pad_out),
      .io_hold(io_hold), .clk_en(clk_en), .core_pwr_en(core_pwr_en),
      .periph_pwr_en(periph_pwr_en), .domain_rst(domain_rst),
      .ram_pwr_en(ram_pwr_en), .in_standby(in_standby)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = 3'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic enter();
      sleep_req = 1'b1;
      tick();
      sleep_req = 1'b0;
      tick();
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      @(negedge clk);
      do_reset();

      // reset state
      chk("R3 reset hold", io_hold, 0);
      chk("R3 reset clk", clk_en, 1);
      chk("R3 reset pwr", core_pwr_en, 1);
      chk("R3 reset rst", domain_rst, 0);
      chk("R4 reset ram", ram_pwr_en, 4'hF);
      rd(3, v); chk("R9 reset flags", v, 0);

      // R1: register write and readback
      wr(0, 8'h3C); rd(0, v); chk("R1 ctrl", v, 8'h3C);
      wr(1, 8'h0A); rd(1, v); chk("R1 wen", v, 8'h0A);
      wr(2, 8'hC6); rd(2, v); chk("R1 wmode", v, 8'hC6);
      wr(4, 8'hFF); rd(4, v); chk("R1 settle", v, 8'h3F);
      wr(5, 8'hFF); rd(5, v); chk("R1 unmapped", v, 0);

      // R2: permit combinations
      for (int c = 0; c < 4; c++) begin
         do_reset();
         wr(0, c);
         enter();
         chk("R2 hold by permit", io_hold, (c == 3) ? 1 : 0);
         chk("R2 standby by permit", in_standby, (c == 3) ? 1 : 0);
      end

      // R3 and R5: entry order and pad freeze
      do_reset();
      wr(1, 1); wr(2, 1); wr(4, 0);
      core_pad_out = 8'hA5;
      wr(0, 3);
      #1 chk("R5 pad follows", pad_out, 8'hA5);
      sleep_req = 1'b1;
      tick();
      sleep_req = 1'b0;
      core_pad_out = 8'h5A;
      #1;
      chk("R3 step1 hold", io_hold, 1);
      chk("R3 step1 clk", clk_en, 1);
      chk("R3 step1 pwr", core_pwr_en, 1);
      chk("R5 step1 pad", pad_out, 8'hA5);
      tick();
      chk("R3 step2 clk", clk_en, 0);
      chk("R3 step2 pwr", core_pwr_en, 1);
      tick();
      chk("R3 step3 core pwr", core_pwr_en, 0);
      chk("R3 step3 periph pwr", periph_pwr_en, 0);
      chk("R3 step3 rst", domain_rst, 1);
      chk("R3 step3 standby", in_standby, 1);
      chk("R5 standby pad", pad_out, 8'hA5);
      wake_pin[0] = 1'b1;
      repeat (12) tick();
      chk("R5 released pad", pad_out, 8'h5A);
      wake_pin = '0;

      // R4: every keep mask
      for (int m = 0; m < 16; m++) begin
         do_reset();
         wr(0, (m << 2) | 3);
         chk("R4 run ram", ram_pwr_en, 4'hF);
         enter();
         chk("R4 standby ram", ram_pwr_en, m);
      end

      // R8: exit timing over settle counts
      for (int si = 0; si < 4; si++) begin
         int s;
         int k;
         s = (si == 3) ? 7 : si;
         wake_pin = '0;
         do_reset();
         wr(1, 1); wr(2, 1); wr(4, s); wr(0, 3);
         enter();
         wake_pin[0] = 1'b1;
         k = -1;
         for (int n = 0; n < 40; n++) begin
            tick();
            if (clk_en && k < 0) begin
               k = n;
               break;
            end
         end
         chk("R8 clock restart cycle", k, s + 4);
         chk("R8 rst still on", domain_rst, 1);
         tick();
         chk("R8 rst released", domain_rst, 0);
         chk("R8 hold still on", io_hold, 1);
         tick();
         chk("R8 hold released", io_hold, 0);
      end

      // R6, R7, R9, R10: sweep pins, modes and enables
      for (int p = 0; p < 4; p++) begin
         for (int md = 0; md < 4; md++) begin
            for (int en = 0; en < 2; en++) begin
               bit exp_rise, exp_fall, woke;
               wake_pin = '0;
               do_reset();
               wr(1, en << p);
               wr(2, md << (2 * p));
               wr(4, 2);
               wr(0, 8'h3F);
               wr(3, 8'hFF);
               rd(3, v); chk("R9 cleared before sleep", v, 0);
               enter();
               chk("R3 sweep standby", in_standby, 1);
               exp_rise = (en == 1) && (md == 1);
               exp_fall = (en == 1) && (md == 0);
               wake_pin[p] = 1'b1;
               repeat (8) tick();
               chk((en == 0) ? "R6 rise" : "R7 rise", in_standby, exp_rise ? 0 : 1);
               woke = exp_rise;
               if (!exp_rise) begin
                  wake_pin[p] = 1'b0;
                  repeat (8) tick();
                  chk((en == 0) ? "R6 fall" : "R7 fall", in_standby, exp_fall ? 0 : 1);
                  woke = exp_fall;
               end
               repeat (10) tick();
               if (woke) begin
                  chk("R8 back to run", io_hold, 0);
                  rd(3, v); chk("R9 flag set", v, 1 << p);
                  rd(0, v); chk("R10 permits cleared", v, 8'h3C);
                  wr(3, 1 << p);
                  rd(3, v); chk("R9 flag cleared", v, 0);
               end else begin
                  rd(3, v); chk((en == 0) ? "R6 no flag" : "R7 no flag", v, 0);
               end
            end
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule